// File: doc/BRIEF.md
# Backend Error Channel Recovery Controller

This controller watches an active-low, level-sensitive fault line from the power stage behind an eight-channel PWM output. A fault is accepted only when the line stays low for a minimum number of master clock cycles. Shorter pulses are discarded. Once a fault is accepted, the controller drives a per-channel mask. The output stage uses this mask to force the selected channels into their fault output state. A configuration input selects the affected set: either all eight channels, or only the first six.

After a fault is accepted, the controller holds the mask for a fixed wait of 5 ms, counted in master clock cycles. It then runs a re-initialization interval and releases the channels. If the line is still low when the wait ends, the wait starts again. A new accepted fault during re-initialization sends the sequence back to the wait. The controller touches nothing else: modulation, volume and register contents are outside it.

Top module: `bkerr_recovery`

## Requirements
- R1: While reset is asserted and right after its release, `chan_fault` is 8'h00 and `busy` is 0.
- R2: A fault is accepted when `fault_n` has been sampled low on QUAL_CYCLES (5) consecutive rising edges of `mclk`. `busy` and the mask rise on the next rising edge, so they are first seen high 6 edges after `fault_n` first goes low.
- R3: A low pulse shorter than QUAL_CYCLES edges leaves `busy` and `chan_fault` unchanged. Any high sample restarts the count, so two 4-cycle pulses split by one high cycle are ignored.
- R4: With `six_ch` sampled 0 at acceptance, `chan_fault` is 8'hFF while busy. Bit i is channel i+1.
- R5: With `six_ch` sampled 1 at acceptance, `chan_fault` is 8'h3F while busy: channels 1 to 6 are forced, and bits 7:6 (channels 7 and 8) stay 0.
- R6: `six_ch` is captured when a fault is accepted. Changing it during a sequence does not alter `chan_fault`.
- R7: If `fault_n` returns high within the first wait, `busy` stays high for exactly HOLD_CYC + REINIT_CYC cycles. HOLD_CYC is CLK_KHZ*HOLD_MS, so 5 ms at the master clock rate. After that, `chan_fault` returns to 0.
- R8: If the fault is still accepted when the wait ends, the wait restarts for another HOLD_CYC cycles before re-initialization.
- R9: A fault accepted during re-initialization returns the controller to a full wait of HOLD_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the source |
| fault_n | input | 1 | Backend fault line, active low, level sensitive |
| six_ch | input | 1 | 1: only channels 1..6 are affected; 0: all eight |
| chan_fault | output | 8 | Per-channel fault-state mask, bit i = channel i+1 |
| busy | output | 1 | High from fault acceptance until re-initialization ends |

## Verification
Two functions can fall in the same cycle: the end of the wait and a still-qualified fault. The re-initialization count can likewise run while a new fault qualifies. The bench provokes the first case by holding `fault_n` low past the first wait, and judges it by the total high time of `busy`: 2*HOLD_CYC + REINIT_CYC. It provokes the second by pulling `fault_n` low again just after re-initialization starts, so that qualification completes before re-initialization would have ended. The expected length of `busy` then changes to include a fresh full wait.

// File: rtl/bkerr_pkg.sv
package bkerr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_REINIT = 2'd2
  } rec_state_e;
endpackage

// File: rtl/bkerr_qual.sv
module bkerr_qual #(
  parameter int QUAL_CYCLES = 5
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic fault_n,
  output logic qualified
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);

  logic [CW-1:0] run_q, run_d;

  always_comb begin
    if (fault_n)           run_d = '0;
    else if (run_q == LIMIT) run_d = run_q;
    else                   run_d = run_q + 1'b1;
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign qualified = (run_q == LIMIT);
endmodule

// File: rtl/bkerr_timer.sv
module bkerr_timer #(
  parameter int W = 8
) (
  input  logic         mclk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/bkerr_mask.sv
module bkerr_mask #(
  parameter int NUM_CH     = 8,
  parameter int REDUCED_CH = 6
) (
  input  logic              active,
  input  logic              reduced,
  output logic [NUM_CH-1:0] mask
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i < REDUCED_CH) begin : g_core
      assign mask[i] = active;
    end else begin : g_upper
      assign mask[i] = active & ~reduced;
    end
  end
endmodule

// File: rtl/bkerr_recovery.sv
module bkerr_recovery #(
  parameter int NUM_CH      = 8,
  parameter int REDUCED_CH  = 6,
  parameter int QUAL_CYCLES = 5,
  parameter int CLK_KHZ     = 24576,
  parameter int HOLD_MS     = 5,
  parameter int REINIT_CYC  = 1024
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              fault_n,
  input  logic              six_ch,
  output logic [NUM_CH-1:0] chan_fault,
  output logic              busy
);
  import bkerr_pkg::*;

  localparam int HOLD_CYC = CLK_KHZ * HOLD_MS;
  localparam int MAX_CYC  = (HOLD_CYC > REINIT_CYC) ? HOLD_CYC : REINIT_CYC;
  localparam int TW       = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] HOLD_LD   = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] REINIT_LD = TW'(REINIT_CYC - 1);

  rec_state_e    state_q, state_d;
  logic          reduced_q, reduced_d;
  logic          qualified, expired;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;

  bkerr_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .mclk(mclk), .rst_n(rst_n), .fault_n(fault_n), .qualified(qualified)
  );

  bkerr_timer #(.W(TW)) u_timer (
    .mclk(mclk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(expired)
  );

  always_comb begin
    state_d   = state_q;
    reduced_d = reduced_q;
    tmr_load  = 1'b0;
    tmr_val   = HOLD_LD;
    unique case (state_q)
      ST_IDLE: if (qualified) begin
        state_d   = ST_HOLD;
        reduced_d = six_ch;
        tmr_load  = 1'b1;
      end
      ST_HOLD: if (expired) begin
        tmr_load = 1'b1;
        if (!qualified) begin
          state_d = ST_REINIT;
          tmr_val = REINIT_LD;
        end
      end
      ST_REINIT: if (qualified) begin
        state_d   = ST_HOLD;
        reduced_d = six_ch;
        tmr_load  = 1'b1;
      end else if (expired) begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      reduced_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      reduced_q <= reduced_d;
    end
  end

  assign busy = (state_q != ST_IDLE);

  bkerr_mask #(.NUM_CH(NUM_CH), .REDUCED_CH(REDUCED_CH)) u_mask (
    .active(busy), .reduced(reduced_q), .mask(chan_fault)
  );
endmodule

// File: rtl/bkerr_recovery_chk.sv
module bkerr_recovery_chk #(
  parameter int NUM_CH      = 8,
  parameter int REDUCED_CH  = 6,
  parameter int QUAL_CYCLES = 5,
  parameter int CLK_KHZ     = 24576,
  parameter int HOLD_MS     = 5,
  parameter int REINIT_CYC  = 1024
) (
  input logic              mclk,
  input logic              rst_n,
  input logic              fault_n,
  input logic [NUM_CH-1:0] chan_fault,
  input logic              busy
);
  localparam int HOLD_CYC = CLK_KHZ * HOLD_MS;
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam int BW = $clog2(HOLD_CYC + REINIT_CYC + 2) + 1;
  localparam logic [NUM_CH-1:0] FULL = '1;
  localparam logic [NUM_CH-1:0] PART = NUM_CH'((1 << REDUCED_CH) - 1);

  logic [QW-1:0] low_run;
  logic [BW-1:0] busy_run;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n)                            low_run <= '0;
    else if (fault_n)                      low_run <= '0;
    else if (low_run != QW'(QUAL_CYCLES))  low_run <= low_run + 1'b1;
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n)                  busy_run <= '0;
    else if (!busy)              busy_run <= '0;
    else if (busy_run != '1)     busy_run <= busy_run + 1'b1;
  end

  AST_RISE_QUALIFIED: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(busy) |-> $past(low_run) == QW'(QUAL_CYCLES)); // R2

  AST_SHORT_IGNORED: assert property (@(posedge mclk) disable iff (!rst_n)
    (!busy && low_run != QW'(QUAL_CYCLES)) |=> !busy); // R3

  AST_MASK_SHAPE: assert property (@(posedge mclk) disable iff (!rst_n)
    busy |-> (chan_fault == FULL || chan_fault == PART)); // R5

  AST_MASK_IDLE: assert property (@(posedge mclk) disable iff (!rst_n)
    !busy |-> chan_fault == '0); // R1

  AST_MASK_HELD: assert property (@(posedge mclk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chan_fault)); // R6

  AST_MIN_DURATION: assert property (@(posedge mclk) disable iff (!rst_n)
    $fell(busy) |-> $past(busy_run) >= BW'(HOLD_CYC + REINIT_CYC - 1)); // R7
endmodule

bind bkerr_recovery bkerr_recovery_chk #(
  .NUM_CH(NUM_CH), .REDUCED_CH(REDUCED_CH), .QUAL_CYCLES(QUAL_CYCLES),
  .CLK_KHZ(CLK_KHZ), .HOLD_MS(HOLD_MS), .REINIT_CYC(REINIT_CYC)
) u_chk (
  .mclk(mclk), .rst_n(rst_n), .fault_n(fault_n),
  .chan_fault(chan_fault), .busy(busy)
);

// File: tb/sim_bkerr_recovery.sv
module sim_bkerr_recovery;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_KHZ    = 4;
  localparam int HOLD_MS    = 5;
  localparam int HOLD_CYC   = CLK_KHZ * HOLD_MS;   // 20
  localparam int REINIT_CYC = 16;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fault_n = 1'b1;
  logic       six_ch = 1'b0;
  logic [7:0] chan_fault;
  logic       busy;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  bkerr_recovery #(
    .NUM_CH(8), .REDUCED_CH(6), .QUAL_CYCLES(5),
    .CLK_KHZ(CLK_KHZ), .HOLD_MS(HOLD_MS), .REINIT_CYC(REINIT_CYC)
  ) u0 (
    .mclk(mclk), .rst_n(rst_n), .fault_n(fault_n), .six_ch(six_ch),
    .chan_fault(chan_fault), .busy(busy)
  );

  always #(CLK_PERIOD/2) mclk = ~mclk;

  always @(posedge mclk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected < 20000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(negedge mclk);
  endtask

  task automatic chk(bit ok, string tag, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h, expected %0h", tag, act, expv);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    chk(chan_fault == 8'h00, "R1 mask in reset", chan_fault, 0);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    tick();
    chk(chan_fault == 8'h00 && !busy, "R1 after release", {busy, chan_fault}, 0);
  endtask

  task automatic t_glitch();
    int seen = 0;
    fault_n = 1'b0; repeat (4) tick();
    fault_n = 1'b1; tick();
    fault_n = 1'b0; repeat (4) tick();
    fault_n = 1'b1;
    repeat (30) begin
      tick();
      if (busy || chan_fault != 0) seen++;
    end
    chk(seen == 0, "R3 short pulses ignored", seen, 0);
  endtask

  // One fault sequence. release_at: busy sample count at which fault_n goes high.
  // reinj_at: if nonzero, fault_n goes low again at that count, high 6 samples later.
  task automatic t_sequence(bit six, int release_at, int reinj_at, bit flip_cfg,
                            int exp_len, string tag);
    int lat = 0;
    int len;
    int bad_mask = 0;
    logic [7:0] exp_mask;
    exp_mask = six ? 8'h3F : 8'hFF;
    six_ch  = six;
    fault_n = 1'b0;
    do begin
      tick();
      lat++;
    end while (!busy && lat < 50);
    chk(lat == 6, {"R2 acceptance latency ", tag}, lat, 6);
    len = 1;
    if (six) chk(chan_fault == exp_mask, "R5 six-channel mask", chan_fault, exp_mask);
    else     chk(chan_fault == exp_mask, "R4 eight-channel mask", chan_fault, exp_mask);
    if (flip_cfg) six_ch = ~six;
    if (release_at == 1) fault_n = 1'b1;
    while (busy && len < 500) begin
      tick();
      if (busy) begin
        if (chan_fault != exp_mask) bad_mask++;
        len++;
        if (len == release_at) fault_n = 1'b1;
        if (reinj_at != 0 && len == reinj_at) fault_n = 1'b0;
        if (reinj_at != 0 && len == reinj_at + 6) fault_n = 1'b1;
      end
    end
    fault_n = 1'b1;
    chk(bad_mask == 0, {"R6 mask held ", tag}, bad_mask, 0);
    chk(len == exp_len, {"busy length ", tag}, len, exp_len);
    chk(chan_fault == 8'h00, {"R7 mask cleared ", tag}, chan_fault, 0);
    repeat (8) tick();
  endtask

  initial begin
    t_reset();
    t_glitch();
    // R7: quick release, full mask
    t_sequence(1'b0, 1, 0, 1'b0, HOLD_CYC + REINIT_CYC, "R7 R4");
    // R5 + R6: six-channel, config flipped mid-sequence
    t_sequence(1'b1, 1, 0, 1'b1, HOLD_CYC + REINIT_CYC, "R5 R6");
    // R8: still low when the wait ends
    t_sequence(1'b0, 25, 0, 1'b0, 2*HOLD_CYC + REINIT_CYC, "R8 restart");
    // R9: new fault qualifies during re-initialization
    t_sequence(1'b0, 1, 22, 1'b0, 27 + HOLD_CYC + REINIT_CYC, "R9 reinit hit");
    t_glitch();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule